// File: doc/BRIEF.md
# IR run-length pulse transmitter

This block drives a consumer infrared emitter from a stream of run-length tokens. A host pushes bytes into a 32-entry transmit queue. A sequencer takes each byte from the queue in turn and plays it as a stretch of modulated carrier (a mark) or of silence (a space). The length of the stretch is a count of duration units. One unit is the programmable divisor times a fixed number of clock cycles per base sample. Bytes follow one another with no gap for as long as the queue holds data. When the queue runs dry, the output goes quiet and a done flag is raised.

The carrier comes from a phase counter that restarts at the start of every byte. Its period is set in clock cycles, which covers both the low-speed band (roughly 27 to 58 kHz) and the high-speed band (400 to 500 kHz) by choice of period. A 3-bit width code sets the carrier high time in eighths of the period. A refill interrupt is raised while the queue occupancy is below one of four coded levels. It needs both its own enable and a global enable. The host can read the occupancy and can empty the queue at any time with a clear strobe.

The sequencer has three states: IDLE, PLAY and FLUSH. Its transitions are as follows.
- IDLE to PLAY (start): the queue is non-empty; the head byte is loaded and popped.
- PLAY to PLAY (chain): a byte ends and the queue still holds data; the next byte loads in the same cycle.
- PLAY to IDLE (drain): a byte ends with the queue empty; done is set.
- Any state to FLUSH (abort): the clear strobe is seen.
- FLUSH to IDLE (settle): the cycle after the abort.

Top module: `irtx_top`

## Requirements
- R1: The queue holds DEPTH (32) bytes, and `fifo_count` gives the occupancy. `fifo_full` is high at 32 entries. An accepted write adds one entry on the next edge. A write while full is dropped, and the count stays at 32.
- R2: In each byte, bit 7 = 0 selects a mark (carrier on) and bit 7 = 1 selects a space (output low). Bits 6:0 hold the run length minus one, so a byte lasts 1 to 128 units.
- R3: One unit lasts max(`unit_div`,1) × SAMPLE_CLKS clock cycles, with SAMPLE_CLKS = 4 by default. Queued bytes play back to back with no idle cycle between them.
- R4: A byte written into an empty, idle queue at clock edge W appears on `ir_out` from the cycle that follows edge W+1.
- R5: During a mark, the carrier phase is 0 in the first cycle of the byte and counts modulo `car_period`. `ir_out` is high when phase×8 < `car_period`×(`pw_code`+1), so code 7 gives a steady high level.
- R6: `thr_code` selects the refill level: code 0 is 1 entry, code 1 is 7, code 2 is 17 and code 3 is 25. `low_irq` = `irq_en_low` & `irq_en_all` & (`fifo_count` < level).
- R7: A `fifo_clr` strobe empties the queue by the next edge. It aborts the byte in progress, so `ir_out` is low from the next cycle, and it clears `tx_done`. A write in the same cycle is dropped.
- R8: When no byte is playing, `ir_out` is low. `tx_done` rises when a byte ends with the queue empty, and the next accepted write clears it.
- R9: After reset the queue is empty, `ir_out` and `tx_done` are low, and `fifo_full` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Push strobe for `wr_data` |
| wr_data | input | 8 | Run-length token |
| fifo_clr | input | 1 | Empty the queue and abort playback |
| thr_code | input | 2 | Refill level code |
| irq_en_low | input | 1 | Refill interrupt enable |
| irq_en_all | input | 1 | Global interrupt enable |
| unit_div | input | DIV_W (8) | Unit divisor, 0 acts as 1 |
| car_period | input | CAR_W (8) | Carrier period in clock cycles |
| pw_code | input | 3 | Carrier high time in eighths |
| ir_out | output | 1 | Modulated emitter drive |
| fifo_count | output | 6 | Queue occupancy |
| fifo_full | output | 1 | Queue holds 32 entries |
| low_irq | output | 1 | Refill interrupt |
| tx_done | output | 1 | Queue drained and last byte finished |

## Verification
The assertions check on every cycle that:
- the occupancy never passes 32 and a dropped write leaves it unchanged;
- an accepted write raises it by one;
- a space and a raised done flag both keep the output low;
- the interrupt never fires without both enables, and fires whenever an enabled, empty queue is seen;
- a clear empties the queue and silences the output on the next cycle.

Only the bench scenarios can show the exact waveform:
- the start latency and the absence of gaps between bytes;
- unit length for each divisor;
- carrier phase and duty for every width code and a range of periods;
- the 128-unit maximum;
- the level chosen by each threshold code at every occupancy.

// File: rtl/irtx_pkg.sv
package irtx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PLAY  = 2'd1,
        ST_FLUSH = 2'd2
    } tx_state_t;

    localparam int TOKEN_W  = 8;
    localparam int LEN_W    = 7;
    localparam int PW_W     = 3;
    localparam int THR_W    = 2;

endpackage

// File: rtl/irtx_fifo.sv
module irtx_fifo #(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic [DW-1:0]    push_data,
    input  logic             pop,
    input  logic             clr,
    output logic [DW-1:0]    head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty,
    output logic             push_ok
);

    logic [DW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             pop_ok;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push_req && !full && !clr;
    assign pop_ok  = pop && !empty && !clr;
    assign head    = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= step(wr_ptr);
            end
            if (pop_ok) begin
                rd_ptr <= step(rd_ptr);
            end
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/irtx_carrier.sv
module irtx_carrier #(
    parameter int CAR_W = 8,
    parameter int PW_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CAR_W-1:0] period,
    input  logic [PW_W-1:0]  pw,
    output logic             car_hi
);

    localparam int EXT_W = CAR_W + PW_W + 1;

    logic [CAR_W-1:0] phase;
    logic [EXT_W-1:0] lhs;
    logic [EXT_W-1:0] rhs;
    logic [EXT_W-1:0] pw_ext;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (restart) begin
            phase <= '0;
        end else if (phase >= period - CAR_W'(1)) begin
            phase <= '0;
        end else begin
            phase <= phase + CAR_W'(1);
        end
    end

    assign pw_ext = EXT_W'(pw) + EXT_W'(1);
    assign lhs    = {1'b0, phase, {PW_W{1'b0}}};
    assign rhs    = EXT_W'(period) * pw_ext;
    assign car_hi = (lhs < rhs);

endmodule

// File: rtl/irtx_seq.sv
module irtx_seq
    import irtx_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int SAMPLE_CLKS = 4,
    localparam int UNIT_W     = DIV_W + $clog2(SAMPLE_CLKS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               empty,
    input  logic [TOKEN_W-1:0] head,
    input  logic               clr,
    input  logic               push_ok,
    input  logic [DIV_W-1:0]   unit_div,
    output logic               pop,
    output logic               byte_start,
    output logic               playing,
    output logic               is_mark,
    output logic               done
);

    tx_state_t           state_q;
    tx_state_t           state_d;
    logic [TOKEN_W-1:0]  cur_q;
    logic [LEN_W-1:0]    units_q;
    logic [UNIT_W-1:0]   sub_q;
    logic [DIV_W-1:0]    div_eff;
    logic [UNIT_W-1:0]   unit_m1;
    logic                unit_end;
    logic                byte_end;
    logic                drain;

    assign div_eff  = (unit_div == '0) ? DIV_W'(1) : unit_div;
    assign unit_m1  = UNIT_W'(div_eff) * UNIT_W'(SAMPLE_CLKS) - UNIT_W'(1);
    assign unit_end = (sub_q >= unit_m1);
    assign byte_end = unit_end && (units_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d    = state_q;
        pop        = 1'b0;
        byte_start = 1'b0;
        drain      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (clr) begin
                    state_d = ST_FLUSH;
                end else if (!empty) begin
                    state_d    = ST_PLAY;
                    pop        = 1'b1;
                    byte_start = 1'b1;
                end
            end
            ST_PLAY: begin
                if (clr) begin
                    state_d = ST_FLUSH;
                end else if (byte_end) begin
                    if (!empty) begin
                        pop        = 1'b1;
                        byte_start = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                        drain   = 1'b1;
                    end
                end
            end
            ST_FLUSH: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q   <= '0;
            units_q <= '0;
            sub_q   <= '0;
        end else if (byte_start) begin
            cur_q   <= head;
            units_q <= head[LEN_W-1:0];
            sub_q   <= '0;
        end else if (state_q == ST_PLAY) begin
            if (unit_end) begin
                sub_q <= '0;
                if (units_q != '0) begin
                    units_q <= units_q - LEN_W'(1);
                end
            end else begin
                sub_q <= sub_q + UNIT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else if (clr || push_ok) begin
            done <= 1'b0;
        end else if (drain) begin
            done <= 1'b1;
        end
    end

    assign playing = (state_q == ST_PLAY);
    assign is_mark = !cur_q[TOKEN_W-1];

endmodule

// File: rtl/irtx_top.sv
module irtx_top
    import irtx_pkg::*;
#(
    parameter int DEPTH       = 32,
    parameter int DIV_W       = 8,
    parameter int CAR_W       = 8,
    parameter int SAMPLE_CLKS = 4,
    localparam int CNT_W      = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [7:0]         wr_data,
    input  logic               fifo_clr,
    input  logic [1:0]         thr_code,
    input  logic               irq_en_low,
    input  logic               irq_en_all,
    input  logic [DIV_W-1:0]   unit_div,
    input  logic [CAR_W-1:0]   car_period,
    input  logic [2:0]         pw_code,
    output logic               ir_out,
    output logic [CNT_W-1:0]   fifo_count,
    output logic               fifo_full,
    output logic               low_irq,
    output logic               tx_done
);

    logic [TOKEN_W-1:0] head_w;
    logic               empty_w;
    logic               push_ok_w;
    logic               pop_w;
    logic               start_w;
    logic               playing_w;
    logic               mark_w;
    logic               car_hi_w;
    logic [CNT_W-1:0]   level_w;

    irtx_fifo #(.DEPTH(DEPTH), .DW(TOKEN_W)) fifo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (wr_en),
        .push_data (wr_data),
        .pop       (pop_w),
        .clr       (fifo_clr),
        .head      (head_w),
        .count     (fifo_count),
        .full      (fifo_full),
        .empty     (empty_w),
        .push_ok   (push_ok_w)
    );

    irtx_seq #(.DIV_W(DIV_W), .SAMPLE_CLKS(SAMPLE_CLKS)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .empty      (empty_w),
        .head       (head_w),
        .clr        (fifo_clr),
        .push_ok    (push_ok_w),
        .unit_div   (unit_div),
        .pop        (pop_w),
        .byte_start (start_w),
        .playing    (playing_w),
        .is_mark    (mark_w),
        .done       (tx_done)
    );

    irtx_carrier #(.CAR_W(CAR_W), .PW_W(PW_W)) car_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (start_w),
        .period  (car_period),
        .pw      (pw_code),
        .car_hi  (car_hi_w)
    );

    always_comb begin
        unique case (thr_code)
            2'd0:    level_w = CNT_W'(1);
            2'd1:    level_w = CNT_W'(7);
            2'd2:    level_w = CNT_W'(17);
            default: level_w = CNT_W'(25);
        endcase
    end

    assign low_irq = irq_en_low && irq_en_all && (fifo_count < level_w);
    assign ir_out  = playing_w && mark_w && car_hi_w;

endmodule

// File: rtl/irtx_chk.sv
module irtx_chk #(
    parameter int DEPTH = 32,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             fifo_clr,
    input logic             irq_en_low,
    input logic             irq_en_all,
    input logic             ir_out,
    input logic [CNT_W-1:0] fifo_count,
    input logic             fifo_full,
    input logic             low_irq,
    input logic             tx_done,
    input logic             pop,
    input logic             playing,
    input logic             mark
);

    assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CNT_W'(DEPTH));

    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full && wr_en && !pop && !fifo_clr |=> $stable(fifo_count));

    assert_push_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !fifo_full && !pop && !fifo_clr |=> fifo_count == $past(fifo_count) + CNT_W'(1));

    assert_space_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        playing && !mark |-> !ir_out);

    assert_irq_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        low_irq |-> irq_en_low && irq_en_all);

    assert_irq_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_en_low && irq_en_all && fifo_count == '0 |-> low_irq);

    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> fifo_count == '0 && !ir_out && !tx_done);

    assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> !ir_out);

endmodule

bind irtx_top irtx_chk #(.DEPTH(DEPTH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .fifo_clr   (fifo_clr),
    .irq_en_low (irq_en_low),
    .irq_en_all (irq_en_all),
    .ir_out     (ir_out),
    .fifo_count (fifo_count),
    .fifo_full  (fifo_full),
    .low_irq    (low_irq),
    .tx_done    (tx_done),
    .pop        (pop_w),
    .playing    (playing_w),
    .mark       (mark_w)
);

// File: tb/irtx_top_tb_top.sv
module irtx_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       fifo_clr = 1'b0;
    logic [1:0] thr_code = 2'd2;
    logic       irq_en_low = 1'b0;
    logic       irq_en_all = 1'b0;
    logic [7:0] unit_div = 8'd1;
    logic [7:0] car_period = 8'd6;
    logic [2:0] pw_code = 3'd3;
    logic       ir_out;
    logic [5:0] fifo_count;
    logic       fifo_full;
    logic       low_irq;
    logic       tx_done;

    int total = 0;
    int bad = 0;
    logic [7:0] sb [8];
    int sn = 0;

    localparam int SAMPLE = 4;

    always #4 clk = ~clk;

    irtx_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .fifo_clr(fifo_clr), .thr_code(thr_code), .irq_en_low(irq_en_low),
        .irq_en_all(irq_en_all), .unit_div(unit_div), .car_period(car_period),
        .pw_code(pw_code), .ir_out(ir_out), .fifo_count(fifo_count),
        .fifo_full(fifo_full), .low_irq(low_irq), .tx_done(tx_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int level_of(input int code);
        case (code)
            0: return 1;
            1: return 7;
            2: return 17;
            default: return 25;
        endcase
    endfunction

    // Plays sb[0..sn-1]; checks waveform per byte (R2, R3, R4, R5) and drain (R8).
    task automatic run_stream(input int dv, input int per, input int pwc);
        unit_div = 8'(dv);
        car_period = 8'(per);
        pw_code = 3'(pwc);
        fork
            begin
                for (int i = 0; i < sn; i++) begin
                    wr_en = 1'b1;
                    wr_data = sb[i];
                    @(negedge clk);
                end
                wr_en = 1'b0;
            end
            begin
                int unit;
                unit = ((dv == 0) ? 1 : dv) * SAMPLE;
                @(negedge clk);
                chk(tx_done == 1'b0, "R8", int'(tx_done), 0);
                @(negedge clk);
                for (int b = 0; b < sn; b++) begin
                    int dur;
                    int miss;
                    bit mk;
                    int exp;
                    int got;
                    dur = (int'(sb[b][6:0]) + 1) * unit;
                    mk = !sb[b][7];
                    miss = 0;
                    exp = 0;
                    got = 0;
                    for (int j = 0; j < dur; j++) begin
                        int e;
                        e = (mk && ((j % per) * 8 < per * (pwc + 1))) ? 1 : 0;
                        if (int'(ir_out) != e) begin
                            if (miss == 0) begin
                                exp = e;
                                got = int'(ir_out);
                            end
                            miss++;
                        end
                        @(negedge clk);
                    end
                    if (mk) chk(miss == 0, "R5", got, exp);
                    else    chk(miss == 0, "R2", got, exp);
                end
                chk(ir_out == 1'b0, "R8", int'(ir_out), 0);
                chk(tx_done == 1'b1, "R8", int'(tx_done), 1);
            end
        join
    endtask

    task automatic clear_now();
        fifo_clr = 1'b1;
        @(negedge clk);
        fifo_clr = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(8ns * 200000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        irq_en_low = 1'b1;
        irq_en_all = 1'b1;
        #1;
        // R9 reset state
        chk(fifo_count == 6'd0, "R9", int'(fifo_count), 0);
        chk(ir_out == 1'b0, "R9", int'(ir_out), 0);
        chk(tx_done == 1'b0, "R9", int'(tx_done), 0);
        chk(fifo_full == 1'b0, "R9", int'(fifo_full), 0);
        chk(low_irq == 1'b1, "R6", int'(low_irq), 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R5: every width code with a fixed period
        sb[0] = 8'h02; sb[1] = 8'h81; sb[2] = 8'h00; sb[3] = 8'h83; sb[4] = 8'h04;
        sn = 5;
        for (int p = 0; p < 8; p++) run_stream(1, 6, p);
        // R3: divisor sweep including zero
        for (int d = 0; d < 4; d++) run_stream(d, 5, 2);
        // R5: period sweep
        for (int c = 2; c < 10; c++) run_stream(1, c, 3);
        // R2: longest runs, mark then space
        sb[0] = 8'h7F; sb[1] = 8'hFF; sb[2] = 8'h00;
        sn = 3;
        run_stream(1, 7, 4);

        // R1: fill to full with long marks, one extra write dropped
        pw_code = 3'd7;
        car_period = 8'd4;
        for (int i = 0; i < 34; i++) begin
            wr_en = 1'b1;
            wr_data = 8'h7F;
            @(negedge clk);
        end
        wr_en = 1'b0;
        #1;
        chk(fifo_count == 6'd32, "R1", int'(fifo_count), 32);
        chk(fifo_full == 1'b1, "R1", int'(fifo_full), 1);
        for (int c = 0; c < 4; c++) begin
            thr_code = 2'(c);
            #1;
            chk(low_irq == 1'b0, "R6", int'(low_irq), 0);
        end
        chk(ir_out == 1'b1, "R5", int'(ir_out), 1);
        // R7: clear with a simultaneous write
        @(negedge clk);
        fifo_clr = 1'b1;
        wr_en = 1'b1;
        wr_data = 8'h10;
        @(negedge clk);
        fifo_clr = 1'b0;
        wr_en = 1'b0;
        #1;
        chk(fifo_count == 6'd0, "R7", int'(fifo_count), 0);
        chk(ir_out == 1'b0, "R7", int'(ir_out), 0);
        chk(tx_done == 1'b0, "R7", int'(tx_done), 0);
        @(negedge clk);
        @(negedge clk);
        chk(fifo_count == 6'd0, "R7", int'(fifo_count), 0);
        chk(ir_out == 1'b0, "R7", int'(ir_out), 0);

        // R6: level sweep over every occupancy and code
        for (int k = 1; k <= 33; k++) begin
            int expc;
            wr_en = 1'b1;
            wr_data = 8'h7F;
            @(negedge clk);
            wr_en = 1'b0;
            @(negedge clk);
            expc = (k - 1 > 32) ? 32 : k - 1;
            chk(int'(fifo_count) == expc, "R1", int'(fifo_count), expc);
            for (int c = 0; c < 4; c++) begin
                int e;
                thr_code = 2'(c);
                #1;
                e = (expc < level_of(c)) ? 1 : 0;
                chk(int'(low_irq) == e, "R6", int'(low_irq), e);
            end
            irq_en_all = 1'b0;
            #1;
            chk(low_irq == 1'b0, "R6", int'(low_irq), 0);
            irq_en_all = 1'b1;
            irq_en_low = 1'b0;
            #1;
            chk(low_irq == 1'b0, "R6", int'(low_irq), 0);
            irq_en_low = 1'b1;
            @(negedge clk);
        end
        clear_now();
        chk(fifo_count == 6'd0, "R7", int'(fifo_count), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule